// File: doc/BRIEF.md
# Four-Lane Readout Aggregator with Slow-Control Injection

This block merges the serial event data of four front-end chains onto one output line. The output carries one bit per clock, and its slots rotate over the four lanes, so each lane moves at a quarter of the output rate. The block stores no events. It acts only as a time-division multiplexer, and it also acts as readout master for every chain. A trigger pulse adds one pending readout to each lane. While a lane has work pending and is idle, the block pulses that lane's read request. When a frame ends, the block requests the next queued readout on its own, so no new trigger is needed.

Monitoring words come in on a small valid/ready port. The block wraps each word in the same preamble and trailer that event frames use, and sets a flag bit that marks the frame as slow-control. A slow-control frame goes only into a lane that is idle and owes no readout, so event traffic always comes first.

Top module: `readout_aggregator`

## Requirements
- R1: While rst_ni is low, ser_o, every rd_req_o bit and sc_data ownership are cleared: ser_o=0, rd_req_o=0 and sc_ready_o=1.
- R2: Output slots rotate in the order lane 0, 1, 2, 3, starting at the first clock edge after reset. The bit that appears after edge e (counted from 0) belongs to lane e mod 4. A lane's input bit is sampled at the edge of its slot.
- R3: Each trig_i cycle adds one pending readout to every lane. A lane that is idle and has readouts pending raises its rd_req_o bit for exactly one cycle, one cycle after the pending count became nonzero.
- R4: When a frame ends and the lane still has readouts pending, the next request comes without any new trigger, exactly two clock edges after the slot edge that saw the frame end.
- R5: Once requested, a lane's bits pass through unchanged in its slots while lane_valid_i is high. The frame ends at the first slot of that lane where lane_valid_i is low. A slot with no frame and no slow-control data carries 0. Every frame begins with a preamble whose first bit is 1.
- R6: The pending count per lane saturates at 2**PEND_W-1 (default 3). Triggers beyond that are lost.
- R7: A slow-control frame is sent MSB first, one bit per slot of its lane. It consists of the PRE_W-bit preamble, then a flag bit of 1, then the SC_W-bit word, then the TRL_W-bit trailer. In event frames the bit after the preamble is 0.
- R8: A slow-control frame starts only in the slot of a lane that has no frame in progress, no pending readout and no trigger in that cycle.
- R9: sc_ready_o is high when no slow-control word is held. A word is taken on sc_valid_i & sc_ready_o. sc_ready_o then stays low until that word's frame has been fully sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger pulse, one pending readout per high cycle |
| lane_data_i | input | 4 | Serial data, one bit per lane |
| lane_valid_i | input | 4 | Frame-valid, one bit per lane |
| rd_req_o | output | 4 | One-cycle read request per lane |
| sc_valid_i | input | 1 | Slow-control word valid |
| sc_data_i | input | SC_W | Slow-control word |
| sc_ready_o | output | 1 | Slow-control holding register free |
| ser_o | output | 1 | Merged serial output |

## Verification
The hardest case to reach is a slow-control word that arrives while every lane still owes readouts. It must wait, and then start only in the first lane that drains, without touching event data. The stimulus reaches this case by firing a burst of triggers and offering a word at once. Frame lengths differ per lane, so the lanes drain at different times. The monitor then rebuilds each lane's stream from the slot order and checks every frame bit by bit. When a flagged frame begins, it also confirms that the lane was quiet. A back-to-back burst and a saturating burst test the request timing and the count limit.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef enum logic [1:0] {
    L_IDLE,
    L_WAIT,
    L_BUSY,
    L_SC
  } lane_st_e;
endpackage

// File: rtl/agg_lane.sv
module agg_lane
  import agg_pkg::*;
#(
  parameter int PEND_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic slot_i,
  input  logic data_i,
  input  logic valid_i,
  input  logic sc_start_i,
  input  logic sc_done_i,
  output logic rd_req_o,
  output logic bit_o,
  output logic sc_ok_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  lane_st_e          st_q, st_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              req_q, req_d;
  logic              frame_done;

  assign frame_done = (st_q == L_BUSY) && slot_i && !valid_i;

  always_comb begin
    pend_d = pend_q;
    if (trig_i && !frame_done && pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
    else if (!trig_i && frame_done)                  pend_d = pend_q - 1'b1;
  end

  always_comb begin
    st_d  = st_q;
    req_d = 1'b0;
    unique case (st_q)
      L_IDLE: begin
        if (sc_start_i) st_d = L_SC;
        else if (pend_q != '0) begin
          st_d  = L_WAIT;
          req_d = 1'b1;
        end
      end
      L_WAIT:  if (slot_i && valid_i) st_d = L_BUSY;
      L_BUSY:  if (frame_done) st_d = L_IDLE;
      L_SC:    if (sc_done_i) st_d = L_IDLE;
      default: st_d = L_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= L_IDLE;
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign rd_req_o = req_q;
  assign bit_o    = (st_q == L_WAIT || st_q == L_BUSY) && valid_i && data_i;
  assign sc_ok_o  = (st_q == L_IDLE) && (pend_q == '0) && !trig_i;

  a_r3_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r3_done_had_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |-> pend_q != '0);
  a_r4_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && pend_q > PEND_W'(1) |=> ##1 rd_req_o);
  a_r6_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q == PEND_MAX && trig_i |=> pend_q == PEND_MAX);
  a_r8_sc_only_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_start_i |-> st_q == L_IDLE && pend_q == '0 && !trig_i);
endmodule

// File: rtl/agg_sc.sv
module agg_sc #(
  parameter int          N_LANES = 4,
  parameter int          SLOT_W  = 2,
  parameter int          SC_W    = 16,
  parameter int          PRE_W   = 16,
  parameter int          TRL_W   = 18,
  parameter logic [PRE_W-1:0] PRE_PAT = '1,
  parameter logic [TRL_W-1:0] TRL_PAT = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sc_valid_i,
  input  logic [SC_W-1:0]    sc_data_i,
  output logic               sc_ready_o,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [N_LANES-1:0] lane_ok_i,
  output logic [N_LANES-1:0] sc_start_o,
  output logic [N_LANES-1:0] sc_done_o,
  output logic               sc_sel_o,
  output logic               sc_bit_o
);
  localparam int SC_LEN = PRE_W + 1 + SC_W + TRL_W;
  localparam int IDX_W  = $clog2(SC_LEN);

  logic [SC_LEN-1:0] frm_q;
  logic              full_q, act_q;
  logic [SLOT_W-1:0] lane_q;
  logic [IDX_W-1:0]  idx_q;
  logic              start, on_lane, last;

  assign start    = full_q && !act_q && lane_ok_i[slot_i];
  assign on_lane  = act_q && (lane_q == slot_i);
  assign last     = on_lane && (idx_q == IDX_W'(SC_LEN - 1));
  assign sc_sel_o = start || on_lane;
  assign sc_bit_o = sc_sel_o && frm_q[SC_LEN-1];
  assign sc_ready_o = !full_q;

  for (genvar i = 0; i < N_LANES; i++) begin : g_sel
    assign sc_start_o[i] = start && (slot_i == SLOT_W'(i));
    assign sc_done_o[i]  = last && (lane_q == SLOT_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q  <= '0;
      full_q <= 1'b0;
      act_q  <= 1'b0;
      lane_q <= '0;
      idx_q  <= '0;
    end else if (sc_valid_i && !full_q) begin
      frm_q  <= {PRE_PAT, 1'b1, sc_data_i, TRL_PAT};
      full_q <= 1'b1;
    end else if (start) begin
      act_q  <= 1'b1;
      lane_q <= slot_i;
      idx_q  <= IDX_W'(1);
      frm_q  <= frm_q << 1;
    end else if (on_lane) begin
      frm_q <= frm_q << 1;
      idx_q <= idx_q + 1'b1;
      if (last) begin
        act_q  <= 1'b0;
        full_q <= 1'b0;
      end
    end
  end

  a_r9_taken_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_valid_i && sc_ready_o |=> !sc_ready_o);
  a_r9_free_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sc_done_o) |=> sc_ready_o);
  a_r8_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sc_start_o));
endmodule

// File: rtl/readout_aggregator.sv
module readout_aggregator #(
  parameter int          N_LANES = 4,
  parameter int          PEND_W  = 2,
  parameter int          SC_W    = 16,
  parameter int          PRE_W   = 16,
  parameter int          TRL_W   = 18,
  parameter logic [PRE_W-1:0] PRE_PAT = 16'hB38F,
  parameter logic [TRL_W-1:0] TRL_PAT = 18'h2C3A5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [N_LANES-1:0] lane_data_i,
  input  logic [N_LANES-1:0] lane_valid_i,
  output logic [N_LANES-1:0] rd_req_o,
  input  logic               sc_valid_i,
  input  logic [SC_W-1:0]    sc_data_i,
  output logic               sc_ready_o,
  output logic               ser_o
);
  localparam int SLOT_W = $clog2(N_LANES);

  logic [SLOT_W-1:0]  slot_q;
  logic [N_LANES-1:0] lane_bit, lane_ok, sc_start, sc_done;
  logic               sc_sel, sc_bit, ser_q;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    agg_lane #(.PEND_W(PEND_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_i     (trig_i),
      .slot_i     (slot_q == SLOT_W'(i)),
      .data_i     (lane_data_i[i]),
      .valid_i    (lane_valid_i[i]),
      .sc_start_i (sc_start[i]),
      .sc_done_i  (sc_done[i]),
      .rd_req_o   (rd_req_o[i]),
      .bit_o      (lane_bit[i]),
      .sc_ok_o    (lane_ok[i])
    );
  end

  agg_sc #(
    .N_LANES(N_LANES), .SLOT_W(SLOT_W), .SC_W(SC_W),
    .PRE_W(PRE_W), .TRL_W(TRL_W), .PRE_PAT(PRE_PAT), .TRL_PAT(TRL_PAT)
  ) u_sc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sc_valid_i (sc_valid_i),
    .sc_data_i  (sc_data_i),
    .sc_ready_o (sc_ready_o),
    .slot_i     (slot_q),
    .lane_ok_i  (lane_ok),
    .sc_start_o (sc_start),
    .sc_done_o  (sc_done),
    .sc_sel_o   (sc_sel),
    .sc_bit_o   (sc_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      ser_q  <= 1'b0;
    end else begin
      slot_q <= (slot_q == SLOT_W'(N_LANES - 1)) ? '0 : slot_q + 1'b1;
      ser_q  <= sc_sel ? sc_bit : lane_bit[slot_q];
    end
  end

  assign ser_o = ser_q;

  a_r2_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q == SLOT_W'(N_LANES - 1) |=> slot_q == '0);
  a_r5_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_sel && !lane_valid_i[slot_q] |=> !ser_o);
  a_r8_sc_not_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sc_start) |-> (sc_start & rd_req_o) == '0);
endmodule

// File: tb/readout_aggregator_bench.sv
module readout_aggregator_bench;
  localparam int N = 4;
  localparam int PEND_W = 2;
  localparam int SC_W = 16;
  localparam int PRE_W = 16;
  localparam int TRL_W = 18;
  localparam logic [PRE_W-1:0] PRE_PAT = 16'hB38F;
  localparam logic [TRL_W-1:0] TRL_PAT = 18'h2C3A5;
  localparam int SC_LEN = PRE_W + 1 + SC_W + TRL_W;
  localparam int FW = 128;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0;
  logic [N-1:0] lane_data = '0, lane_valid = '0, rd_req;
  logic sc_valid = 1'b0;
  logic [SC_W-1:0] sc_data = '0;
  logic sc_ready, ser;

  readout_aggregator #(
    .N_LANES(N), .PEND_W(PEND_W), .SC_W(SC_W), .PRE_W(PRE_W), .TRL_W(TRL_W),
    .PRE_PAT(PRE_PAT), .TRL_PAT(TRL_PAT)
  ) u_readout_aggregator (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i),
    .lane_data_i(lane_data), .lane_valid_i(lane_valid), .rd_req_o(rd_req),
    .sc_valid_i(sc_valid), .sc_data_i(sc_data), .sc_ready_o(sc_ready), .ser_o(ser)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, ecnt = 0, sc_seen = 0;
  bit done_flag = 0;
  bit b2b_chk = 0;

  bit src_act[N];
  int src_idx[N], src_len[N], req_cnt[N], done_e[N];
  logic [FW-1:0] src_frm[N];
  logic [FW-1:0] ev_q[N][$];
  int ev_len[N][$];
  logic [FW-1:0] sc_q[$];

  bit mon_in[N], mon_sc[N], mon_quiet[N];
  int mon_idx[N], mon_len[N];
  logic [FW-1:0] mon_buf[N];

  task automatic chk(bit ok, string req, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk_frame(bit flag, int plen, logic [SC_W-1:0] w);
    logic [FW-1:0] f = '0;
    int p = 0;
    for (int i = 0; i < PRE_W; i++) begin f[FW-1-p] = PRE_PAT[PRE_W-1-i]; p++; end
    f[FW-1-p] = flag; p++;
    for (int i = 0; i < plen; i++) begin
      f[FW-1-p] = flag ? w[SC_W-1-i] : 1'($urandom % 2);
      p++;
    end
    for (int i = 0; i < TRL_W; i++) begin f[FW-1-p] = TRL_PAT[TRL_W-1-i]; p++; end
    return f;
  endfunction

  always @(posedge clk) if (rst_ni) ecnt <= ecnt + 1;

  // lane sources: answer each read request with one event frame
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int k = 0; k < N; k++) begin
        if (src_act[k] && ecnt > 0 && ((ecnt - 1) % N) == k) begin
          src_idx[k]++;
          if (src_idx[k] == src_len[k]) begin
            src_act[k] = 0;
            done_e[k] = ecnt;
          end
        end
        if (rd_req[k]) begin
          int plen;
          if (b2b_chk && req_cnt[k] > 0)
            chk(ecnt - done_e[k] == 5, "R4", $sformatf("lane %0d request delay", k),
                FW'(ecnt - done_e[k]), FW'(5));
          plen = 2 + ((k * 5 + req_cnt[k] * 7 + ecnt) % 19);
          src_frm[k] = mk_frame(1'b0, plen, '0);
          src_len[k] = PRE_W + 1 + plen + TRL_W;
          ev_q[k].push_back(src_frm[k]);
          ev_len[k].push_back(src_len[k]);
          src_act[k] = 1;
          src_idx[k] = 0;
          req_cnt[k]++;
        end
        lane_valid[k] = src_act[k];
        lane_data[k]  = src_act[k] ? src_frm[k][FW-1-src_idx[k]] : 1'b0;
      end
    end
  end

  // monitor: demultiplex slots and compare frames
  always @(negedge clk) begin
    if (rst_ni && ecnt > 0) begin
      int l;
      l = (ecnt - 1) % N;
      if (!mon_in[l]) begin
        if (ser) begin
          mon_in[l] = 1;
          mon_sc[l] = 0;
          mon_buf[l] = '0;
          mon_buf[l][FW-1] = 1'b1;
          mon_idx[l] = 1;
          mon_len[l] = 0;
          mon_quiet[l] = !src_act[l] && ev_q[l].size() == 0;
        end
      end else begin
        mon_buf[l][FW-1-mon_idx[l]] = ser;
        mon_idx[l]++;
        if (mon_idx[l] == PRE_W + 1) begin
          if (ser) begin
            mon_sc[l] = 1;
            mon_len[l] = SC_LEN;
            chk(mon_quiet[l], "R8", $sformatf("slow-control on busy lane %0d", l),
                FW'(mon_quiet[l]), FW'(1));
          end else if (ev_len[l].size() == 0) begin
            chk(0, "R5", $sformatf("unexpected frame on lane %0d", l), mon_buf[l], '0);
            mon_in[l] = 0;
          end else begin
            mon_len[l] = ev_len[l][0];
          end
        end
        if (mon_in[l] && mon_len[l] != 0 && mon_idx[l] == mon_len[l]) begin
          logic [FW-1:0] exp;
          if (mon_sc[l]) begin
            exp = sc_q.size() ? sc_q.pop_front() : '0;
            sc_seen++;
            chk(mon_buf[l] == exp, "R7", $sformatf("slow-control frame lane %0d", l),
                mon_buf[l], exp);
          end else begin
            exp = ev_q[l].pop_front();
            void'(ev_len[l].pop_front());
            chk(mon_buf[l] == exp, "R2 R5", $sformatf("event frame lane %0d", l),
                mon_buf[l], exp);
          end
          mon_in[l] = 0;
        end
      end
    end
  end

  task automatic pulse_trig(int n);
    @(negedge clk);
    trig_i = 1'b1;
    repeat (n) @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic send_sc(logic [SC_W-1:0] w);
    @(negedge clk);
    while (!sc_ready) @(negedge clk);
    sc_valid = 1'b1;
    sc_data = w;
    sc_q.push_back(mk_frame(1'b1, SC_W, w));
    @(negedge clk);
    sc_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (sc_ready && rd_req == '0 && !(src_act[0] | src_act[1] | src_act[2] | src_act[3])
          && !(mon_in[0] | mon_in[1] | mon_in[2] | mon_in[3])) q++;
      else q = 0;
    end
  endtask

  task automatic clear_counts();
    for (int k = 0; k < N; k++) req_cnt[k] = 0;
    sc_seen = 0;
  endtask

  task automatic check_reqs(int exp, string req);
    for (int k = 0; k < N; k++)
      chk(req_cnt[k] == exp, req, $sformatf("lane %0d request count", k),
          FW'(req_cnt[k]), FW'(exp));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      src_act[k] = 0; src_idx[k] = 0; src_len[k] = 0; req_cnt[k] = 0; done_e[k] = 0;
      mon_in[k] = 0; mon_sc[k] = 0; mon_quiet[k] = 0; mon_idx[k] = 0; mon_len[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser == 1'b0, "R1", "ser_o in reset", FW'(ser), '0);
    chk(rd_req == '0, "R1", "rd_req_o in reset", FW'(rd_req), '0);
    chk(sc_ready == 1'b1, "R1", "sc_ready_o in reset", FW'(sc_ready), FW'(1));
    rst_ni = 1'b1;

    // R3 single trigger, one request per lane
    clear_counts();
    pulse_trig(1);
    wait_quiet();
    check_reqs(1, "R3");

    // R4 two triggers, second readout back to back
    clear_counts();
    b2b_chk = 1;
    pulse_trig(2);
    wait_quiet();
    b2b_chk = 0;
    check_reqs(2, "R4");

    // R6 six triggers against a limit of three
    clear_counts();
    pulse_trig(6);
    wait_quiet();
    check_reqs(3, "R6");

    // R7 slow-control on idle lanes
    clear_counts();
    send_sc(16'hA5C3);
    wait_quiet();
    chk(sc_seen == 1, "R7", "slow-control frames seen", FW'(sc_seen), FW'(1));

    // R8 slow-control offered while every lane owes readouts
    clear_counts();
    pulse_trig(2);
    send_sc(16'h3C96);
    wait_quiet();
    check_reqs(2, "R8");
    chk(sc_seen == 1, "R8", "deferred slow-control frame seen", FW'(sc_seen), FW'(1));

    // R9 holding register, second word waits, trigger during slow-control
    clear_counts();
    send_sc(16'h0FF1);
    chk(sc_ready == 1'b0, "R9", "sc_ready_o after accept", FW'(sc_ready), '0);
    send_sc(16'hE817);
    pulse_trig(1);
    wait_quiet();
    chk(sc_seen == 2, "R9", "both slow-control frames seen", FW'(sc_seen), FW'(2));
    chk(sc_ready == 1'b1, "R9", "sc_ready_o after drain", FW'(sc_ready), FW'(1));
    check_reqs(1, "R3");

    for (int k = 0; k < N; k++)
      chk(ev_q[k].size() == 0, "R5", $sformatf("lane %0d frames outstanding", k),
          FW'(ev_q[k].size()), '0);
    chk(sc_q.size() == 0, "R7", "slow-control frames outstanding", FW'(sc_q.size()), '0);
    finish_run();
  end
endmodule